// File: doc/BRIEF.md
# Hypercube Node Routing Unit

This block is the packet router inside one node of a d-dimensional binary hypercube. A node owns a d-bit label and has one bidirectional link per dimension. The neighbour across dimension k has the node's label with bit k inverted. Packets arrive on any of the d link inputs or on a local injection input. Each packet carries a destination label, a hop counter and a data word. The unit takes the XOR of its own label and the destination. When the XOR is zero, it hands the packet to the local delivery output. Otherwise it forwards the packet on the link of the lowest differing bit, so a packet's route fixes its address bits in ascending order. The number of links on the route equals the Hamming distance between source and destination.

Each input owns a one-entry holding slot. When several slots want the same output in one cycle, a round-robin arbiter for that output grants one. The others stay in their slots, and their ready signals stay low. The hop counter goes up by one on every forward. A packet that would need more than d hops is discarded and raises a one-cycle error pulse. The node label is an input, so one netlist serves every node of the cube.

Port numbering is fixed. Input and output indices 0 to d-1 are the links for dimensions 0 to d-1. Input index d is the local injection input, and output index d is local delivery. Flat vector ports pack entry i at bits [i*W +: W].

Top module: `hc_node_router`

## Requirements
- R1: During and right after a synchronous active-low reset, every out_valid bit and hop_err are 0 and every in_ready bit is 1; a packet held in a slot when reset arrives is discarded.
- R2: A packet whose destination equals node_label leaves on output index DIM (delivery) with its hop count unchanged and its data intact.
- R3: Any other packet leaves on output index k, where k is the lowest set bit of (node_label XOR destination); no other output is valid that cycle.
- R4: A forwarded packet's hop field on the link output equals its input hop field plus one.
- R5: An input is ready whenever its slot is empty. An uncontended packet accepted at clock edge N is valid on its output for one cycle after edge N+1.
- R6: A packet that needs forwarding but arrives with a hop field of DIM or more produces no output. hop_err is 1 in the cycle the packet would have appeared, and 0 otherwise.
- R7: At most one packet per output per cycle. Inputs that lose arbitration keep their packet and hold in_ready at 0 until they are granted.
- R8: Each output arbitrates round robin. After it grants input i, the search for its next grant starts at input i+1 and wraps past DIM to 0; the search starts at input 0 after reset.
- R9: Packets held in different slots that target different outputs leave in the same cycle.
- R10: A packet relayed from node to node reaches its destination after exactly popcount(source XOR destination) forwards, never more than DIM, and arrives with that hop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_label | input | DIM | This node's label in the cube |
| in_valid | input | DIM+1 | Packet present on each input (index DIM = local injection) |
| in_ready | output | DIM+1 | Input slot can accept a packet this cycle |
| in_dest | input | (DIM+1)*DIM | Destination label per input |
| in_hops | input | (DIM+1)*HW | Hop count per input, HW = clog2(DIM+2) |
| in_data | input | (DIM+1)*DW | Data word per input |
| out_valid | output | DIM+1 | Packet leaving on each output (index DIM = delivery) |
| out_dest | output | (DIM+1)*DIM | Destination label per output |
| out_hops | output | (DIM+1)*HW | Hop count per output |
| out_data | output | (DIM+1)*DW | Data word per output |
| hop_err | output | 1 | One-cycle pulse when a packet exceeds the hop limit and is discarded |

## Verification
A wrong route calculation shows one cycle after capture: the packet comes out on a link whose dimension bit is not the lowest differing one, or arrives at delivery with a foreign label. A corrupted round-robin pointer changes which of two contending packets comes out first. That is visible on out_data within the first contended cycle. A slot that loses or duplicates a packet shows up as a missing or repeated data word. It can also show as in_ready stuck low over the following cycles. In a relayed walk, a hop counter error appears at delivery as a count that differs from the Hamming distance.

// File: rtl/hc_pkg.sv
// Shared helpers for the hypercube node router.
// Assumes vectors of at most 32 bits are passed to the helpers.
package hc_pkg;

    // Index of the lowest set bit; returns 0 for an all-zero vector.
    function automatic int lsb_index(logic [31:0] v);
        int idx;
        idx = 0;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) idx = k;
        end
        return idx;
    endfunction

    // Add two indices modulo n (both operands already below n).
    function automatic int wrap_add(int a, int b, int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/hc_route_calc.sv
// Route decision for one held packet.
// Picks delivery when the destination matches the label, otherwise the link
// of the lowest differing label bit. Flags a discard when the packet has
// already used DIM hops and would need another. Purely combinational.
module hc_route_calc #(
    parameter int DIM = 3,
    parameter int HW  = $clog2(DIM + 2)
) (
    input  logic [DIM-1:0] label,
    input  logic [DIM-1:0] dest,
    input  logic [HW-1:0]  hops,
    output logic [DIM:0]   target,
    output logic           drop
);
    import hc_pkg::*;

    logic [DIM-1:0] diff;

    // Form the one-hot target output and the hop-limit discard flag.
    always_comb begin
        diff   = label ^ dest;
        target = '0;
        if (diff == '0) target[DIM] = 1'b1;
        else            target[lsb_index(32'(diff))] = 1'b1;
        drop = (diff != '0) && (32'(hops) >= DIM);
    end

endmodule

// File: rtl/hc_rr_arb.sv
// Round-robin arbiter for one output.
// Grants at most one requester per cycle. The search starts at the pointer,
// which moves to one past the last winner. Assumes N >= 2.
module hc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    import hc_pkg::*;

    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;
    int            win;
    logic          any;

    // Find the first requester at or after the pointer.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        win   = 0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = wrap_add(int'(ptr), off, N);
            if (!any && req[idx]) begin
                grant[idx] = 1'b1;
                any        = 1'b1;
                win        = idx;
            end
        end
    end

    // Move the pointer past the winner after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (any) ptr <= PW'(wrap_add(win, 1, N));
    end

endmodule

// File: rtl/hc_in_slot.sv
// One-entry holding slot for one router input.
// Accepts whenever empty or being emptied in the same cycle. Assumes the
// upstream sender holds in_valid until it sees in_ready.
module hc_in_slot #(
    parameter int DIM = 3,
    parameter int HW  = $clog2(DIM + 2),
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DIM-1:0] in_dest,
    input  logic [HW-1:0]  in_hops,
    input  logic [DW-1:0]  in_data,
    input  logic           leave,
    output logic           s_valid,
    output logic [DIM-1:0] s_dest,
    output logic [HW-1:0]  s_hops,
    output logic [DW-1:0]  s_data
);

    // Ready when the slot is free or its packet departs this cycle.
    assign in_ready = !s_valid || leave;

    // Capture a new packet or release the departing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_dest  <= '0;
            s_hops  <= '0;
            s_data  <= '0;
        end else if (in_valid && in_ready) begin
            s_valid <= 1'b1;
            s_dest  <= in_dest;
            s_hops  <= in_hops;
            s_data  <= in_data;
        end else if (leave) begin
            s_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/hc_node_router.sv
// Hypercube node router top.
// Indices 0..DIM-1 are the dimension links; index DIM is local injection on
// the input side and local delivery on the output side. Each input has a
// slot, each output a round-robin arbiter and a registered output stage.
// Assumes node_label is stable while packets are in flight.
module hc_node_router #(
    parameter int DIM = 3,
    parameter int DW  = 8,
    parameter int NP  = DIM + 1,
    parameter int HW  = $clog2(DIM + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIM-1:0]   node_label,
    input  logic [NP-1:0]    in_valid,
    output logic [NP-1:0]    in_ready,
    input  logic [NP*DIM-1:0] in_dest,
    input  logic [NP*HW-1:0] in_hops,
    input  logic [NP*DW-1:0] in_data,
    output logic [NP-1:0]    out_valid,
    output logic [NP*DIM-1:0] out_dest,
    output logic [NP*HW-1:0] out_hops,
    output logic [NP*DW-1:0] out_data,
    output logic             hop_err
);

    logic [NP-1:0]  s_valid;
    logic [DIM-1:0] s_dest [NP];
    logic [HW-1:0]  s_hops [NP];
    logic [DW-1:0]  s_data [NP];
    logic [NP-1:0]  target [NP];
    logic [NP-1:0]  drop;
    logic [NP-1:0]  leave;
    logic [NP-1:0]  req    [NP];
    logic [NP-1:0]  gnt    [NP];

    // One slot and one route decision per input.
    for (genvar i = 0; i < NP; i++) begin : g_in
        hc_in_slot #(.DIM(DIM), .HW(HW), .DW(DW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_ready (in_ready[i]),
            .in_dest  (in_dest[i*DIM +: DIM]),
            .in_hops  (in_hops[i*HW +: HW]),
            .in_data  (in_data[i*DW +: DW]),
            .leave    (leave[i]),
            .s_valid  (s_valid[i]),
            .s_dest   (s_dest[i]),
            .s_hops   (s_hops[i]),
            .s_data   (s_data[i])
        );
        hc_route_calc #(.DIM(DIM), .HW(HW)) u_route (
            .label  (node_label),
            .dest   (s_dest[i]),
            .hops   (s_hops[i]),
            .target (target[i]),
            .drop   (drop[i])
        );
    end

    // Turn per-input targets into per-output request vectors.
    always_comb begin
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req[o][i] = s_valid[i] && target[i][o] && !drop[i];
            end
        end
    end

    // A slot empties when granted or discarded for the hop limit.
    always_comb begin
        for (int i = 0; i < NP; i++) begin
            leave[i] = s_valid[i] && drop[i];
            for (int o = 0; o < NP; o++) begin
                leave[i] = leave[i] || gnt[o][i];
            end
        end
    end

    // One arbiter and one registered stage per output.
    for (genvar o = 0; o < NP; o++) begin : g_out
        localparam bit IS_LINK = (o < DIM);

        logic [DIM-1:0] m_dest;
        logic [HW-1:0]  m_hops;
        logic [DW-1:0]  m_data;

        hc_rr_arb #(.N(NP)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[o]),
            .grant (gnt[o])
        );

        // Select the granted slot's fields, counting a hop on links.
        always_comb begin
            m_dest = '0;
            m_hops = '0;
            m_data = '0;
            for (int i = 0; i < NP; i++) begin
                if (gnt[o][i]) begin
                    m_dest = s_dest[i];
                    m_hops = IS_LINK ? s_hops[i] + HW'(1) : s_hops[i];
                    m_data = s_data[i];
                end
            end
        end

        // Register the selected packet onto the output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid[o]              <= 1'b0;
                out_dest[o*DIM +: DIM]    <= '0;
                out_hops[o*HW +: HW]      <= '0;
                out_data[o*DW +: DW]      <= '0;
            end else begin
                out_valid[o]              <= |gnt[o];
                out_dest[o*DIM +: DIM]    <= m_dest;
                out_hops[o*HW +: HW]      <= m_hops;
                out_data[o*DW +: DW]      <= m_data;
            end
        end
    end

    // Pulse the error flag when a held packet is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) hop_err <= 1'b0;
        else        hop_err <= |(s_valid & drop);
    end

endmodule

// File: rtl/hc_node_router_chk.sv
// Assertion checker for hc_node_router, attached by bind.
// Assumes node_label is stable while an output is valid.
module hc_node_router_chk #(
    parameter int DIM = 3,
    parameter int NP  = DIM + 1,
    parameter int HW  = $clog2(DIM + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIM-1:0]    node_label,
    input logic [NP-1:0]     in_valid,
    input logic [NP-1:0]     in_ready,
    input logic [NP-1:0]     out_valid,
    input logic [NP*DIM-1:0] out_dest,
    input logic [NP*HW-1:0]  out_hops
);

    // R2: the delivery output only carries packets addressed to this node.
    a_r2_deliver_own_label: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[DIM] |-> (out_dest[DIM*DIM +: DIM] == node_label));

    for (genvar k = 0; k < DIM; k++) begin : g_link
        localparam logic [DIM-1:0] BELOW = DIM'((1 << k) - 1);
        // R3: link k is used only when bit k is the lowest differing bit.
        a_r3_lowest_dim: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> (((out_dest[k*DIM +: DIM] ^ node_label) >> k) & 1) == 1
                             && ((out_dest[k*DIM +: DIM] ^ node_label) & BELOW) == '0);
    end

    for (genvar o = 0; o < NP; o++) begin : g_all
        // R6: no packet leaves with a hop count above DIM.
        a_r6_hops_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (32'(out_hops[o*HW +: HW]) <= DIM));
        // R7: a slot only becomes busy after a packet was offered to it.
        a_r7_ready_drop_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(in_ready[o]) |-> $past(in_valid[o]));
    end

endmodule

bind hc_node_router hc_node_router_chk #(.DIM(DIM), .NP(NP), .HW(HW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_label (node_label),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_dest   (out_dest),
    .out_hops   (out_hops)
);

// File: tb/tb_hc_node_router.sv
`timescale 1ns/1ps
module tb_hc_node_router;
    localparam int DIM = 3;
    localparam int DW  = 8;
    localparam int NP  = DIM + 1;
    localparam int HW  = $clog2(DIM + 2);

    logic              clk;
    logic              rst_n;
    logic [DIM-1:0]    node_label;
    logic [NP-1:0]     in_valid;
    logic [NP-1:0]     in_ready;
    logic [NP*DIM-1:0] in_dest;
    logic [NP*HW-1:0]  in_hops;
    logic [NP*DW-1:0]  in_data;
    logic [NP-1:0]     out_valid;
    logic [NP*DIM-1:0] out_dest;
    logic [NP*HW-1:0]  out_hops;
    logic [NP*DW-1:0]  out_data;
    logic              hop_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    hc_node_router #(.DIM(DIM), .DW(DW)) dut (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Vector: port[14:13] dest[12:10] hops[9:7] exp_out[6:4] (4 = none) exp_hops[3:1] err[0]
    // Node label for the table is 3'b101.
    localparam logic [14:0] VEC [8] = '{
        {2'd3, 3'b101, 3'd0, 3'd3, 3'd0, 1'b0},
        {2'd3, 3'b100, 3'd0, 3'd0, 3'd1, 1'b0},
        {2'd0, 3'b111, 3'd1, 3'd1, 3'd2, 1'b0},
        {2'd1, 3'b001, 3'd2, 3'd2, 3'd3, 1'b0},
        {2'd2, 3'b010, 3'd0, 3'd0, 3'd1, 1'b0},
        {2'd3, 3'b011, 3'd0, 3'd1, 3'd1, 1'b0},
        {2'd0, 3'b100, 3'd3, 3'd4, 3'd0, 1'b1},
        {2'd2, 3'b101, 3'd3, 3'd3, 3'd3, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0;
        in_dest  = '0;
        in_hops  = '0;
        in_data  = '0;
    endtask

    task automatic put(input int p, input logic [DIM-1:0] d, input logic [HW-1:0] h,
                       input logic [DW-1:0] x);
        in_valid[p]           = 1'b1;
        in_dest[p*DIM +: DIM] = d;
        in_hops[p*HW +: HW]   = h;
        in_data[p*DW +: DW]   = x;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int o_hops(input int o);
        return int'(out_hops[o*HW +: HW]);
    endfunction

    function automatic int o_data(input int o);
        return int'(out_data[o*DW +: DW]);
    endfunction

    // Relay a packet node to node, re-labelling the DUT at each hop (R10).
    task automatic walk(input logic [DIM-1:0] src, input logic [DIM-1:0] dst);
        logic [DIM-1:0] cur;
        int port, hops, cnt, k;
        bit arrived;
        cur = src; port = DIM; hops = 0; cnt = 0; arrived = 0;
        for (int s = 0; s < DIM + 2 && !arrived; s++) begin
            node_label = cur;
            put(port, dst, HW'(hops), 8'h5A);
            @(posedge clk); @(negedge clk);
            clear_in();
            step();
            if (out_valid[DIM]) begin
                arrived = 1;
                chk(o_hops(DIM) == cnt, "R10 delivered hop count", o_hops(DIM), cnt);
            end else begin
                k = -1;
                for (int j = DIM - 1; j >= 0; j--) if (out_valid[j]) k = j;
                if (k < 0) begin
                    chk(0, "R10 packet lost in walk", 0, 1);
                    arrived = 1;
                end else begin
                    hops = o_hops(k);
                    cur  = cur ^ DIM'(1 << k);
                    port = k;
                    cnt++;
                end
            end
            step();
        end
        chk(arrived && cnt == $countones(src ^ dst), "R10 forwards equal Hamming distance",
            cnt, $countones(src ^ dst));
        chk(cnt <= DIM, "R10 forwards within DIM", cnt, DIM);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        node_label = 3'b101;
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready in reset", int'(in_ready), 15);
        chk(hop_err == 1'b0, "R1 hop_err in reset", int'(hop_err), 0);
        rst_n = 1'b1;
        step();

        // Table walk: R2, R3, R4, R5, R6
        for (int v = 0; v < 8; v++) begin
            logic [14:0] e;
            int p, eo, eh;
            logic [NP-1:0] ev;
            e  = VEC[v];
            p  = int'(e[14:13]);
            eo = int'(e[6:4]);
            eh = int'(e[3:1]);
            ev = (eo == 4) ? '0 : NP'(1 << eo);
            chk(in_ready[p], "R5 ready when slot empty", int'(in_ready[p]), 1);
            put(p, e[12:10], e[9:7], DW'(8'h40 + v));
            @(posedge clk); @(negedge clk);
            clear_in();
            step();
            chk(out_valid == ev, $sformatf("R3 output select vec%0d", v), int'(out_valid), int'(ev));
            chk(hop_err == e[0], $sformatf("R6 hop_err vec%0d", v), int'(hop_err), int'(e[0]));
            if (eo != 4) begin
                chk(o_hops(eo) == eh, $sformatf("R4 hop field vec%0d", v), o_hops(eo), eh);
                chk(o_data(eo) == 8'h40 + v, $sformatf("R2 data intact vec%0d", v),
                    o_data(eo), 8'h40 + v);
            end
        end
        step();
        chk(out_valid == '0 && hop_err == 1'b0, "R5 R6 single-cycle pulses",
            int'(out_valid), 0);

        // R7: three inputs contend for link 1 (dest 111 from label 101)
        put(0, 3'b111, 0, 8'hA0);
        put(1, 3'b111, 0, 8'hA1);
        put(2, 3'b111, 0, 8'hA2);
        @(posedge clk); @(negedge clk);
        clear_in();
        chk(in_ready[1] == 1'b0 && in_ready[2] == 1'b0, "R7 losers hold ready low",
            int'(in_ready[2:1]), 0);
        step();
        chk(out_valid == 4'b0010, "R7 one grant per output", int'(out_valid), 2);
        chk(o_data(1) == 8'hA0, "R8 first winner input 0", o_data(1), 8'hA0);
        chk(in_ready[2] == 1'b0, "R7 input 2 still waiting", int'(in_ready[2]), 0);
        step();
        chk(o_data(1) == 8'hA1 && out_valid[1], "R8 second winner input 1", o_data(1), 8'hA1);
        step();
        chk(o_data(1) == 8'hA2 && out_valid[1], "R8 third winner input 2", o_data(1), 8'hA2);
        step();
        chk(out_valid == '0, "R7 queue drained", int'(out_valid), 0);

        // R8: pointer now past input 2, so input 3 beats input 0
        put(0, 3'b111, 0, 8'hB0);
        put(3, 3'b111, 0, 8'hB3);
        @(posedge clk); @(negedge clk);
        clear_in();
        step();
        chk(o_data(1) == 8'hB3, "R8 rotation favours input 3", o_data(1), 8'hB3);
        step();
        chk(o_data(1) == 8'hB0 && out_valid[1], "R8 input 0 follows", o_data(1), 8'hB0);
        step();

        // R9: different outputs proceed together
        put(0, 3'b100, 1, 8'hC0);
        put(1, 3'b101, 2, 8'hC1);
        @(posedge clk); @(negedge clk);
        clear_in();
        step();
        chk(out_valid == 4'b1001, "R9 parallel outputs", int'(out_valid), 9);
        chk(o_data(0) == 8'hC0 && o_data(3) == 8'hC1, "R9 parallel data", o_data(3), 8'hC1);
        step();

        // R10: relayed walks
        walk(3'b000, 3'b111);
        walk(3'b110, 3'b011);
        walk(3'b100, 3'b100);
        walk(3'b011, 3'b010);

        // R1: reset while a packet is held
        node_label = 3'b101;
        put(0, 3'b000, 0, 8'h77);
        @(posedge clk); @(negedge clk);
        clear_in();
        rst_n = 1'b0;
        step();
        chk(out_valid == '0, "R1 reset suppresses output", int'(out_valid), 0);
        chk(in_ready == '1, "R1 reset empties slots", int'(in_ready), 15);
        rst_n = 1'b1;
        step();
        chk(out_valid == '0, "R1 held packet discarded", int'(out_valid), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule